// File: doc/BRIEF.md
# Stack Pointer and Context-Save Sequencer

This block keeps the stack pointer of a small 8-bit processor core and produces the byte-wide memory accesses that move data on and off a 64-byte stack window. The pointer is a 16-bit value. Only its low six bits move; the upper bits always select the page at 0x0100. Software-level single-byte push and pop requests each take one cycle. Four framed operations take more than one cycle: a subroutine call and its return, which move two bytes, and an interrupt entry and its return, which move five bytes.

The core sends a command code with a valid strobe. The block drives address, write strobe, read strobe and write data to an external stack memory, and it reads that memory asynchronously through `mem_rdata`. Restored context appears on registered outputs when a return completes. The first byte of every command is transferred in the cycle the command is accepted. `busy` covers the remaining cycles of a framed operation. While `busy` is high, the block ignores every request.

Top module: `stk_ctx_unit`

## Requirements
- R1: `sp` and every `mem_addr` used for an access lie in 0x0100..0x013F; bits 15..6 are always 0x004.
- R2: After reset, and in the cycle after an accepted reset-pointer command (code 6), `sp` is 0x013F. The reset-pointer command makes no memory access.
- R3: Push (code 0) writes `push_byte` at `sp` in the accept cycle, then `sp` decrements. Pop (code 1) reads at `sp`+1, then `sp` increments. `pop_valid` pulses in the next cycle with the byte on `pop_byte`. Write and read are never asserted together.
- R4: A decrement from 0x0100 wraps `sp` to 0x013F with no indication, and later pushes overwrite the older bytes.
- R5: An increment from 0x013F wraps `sp` to 0x0100, so that pop reads address 0x0100.
- R6: Call (code 2) writes the PC low byte at `sp` and the PC high byte at `sp`-1 in two consecutive cycles, leaving `sp` lowered by 2. Return (code 3) pops the high byte and then the low byte, and presents `pc_out` with a one-cycle `restore_valid`.
- R7: Interrupt entry (code 4) writes PC low, PC high, X, A and CC at five descending addresses starting at `sp`, using context sampled in the accept cycle. Interrupt return (code 5) pops CC, A, X, PC high and PC low, and restores all four outputs.
- R8: `busy` is high from the cycle after a call, return, interrupt entry or interrupt return is accepted, through the cycle of its last byte (1 cycle for two-byte frames, 4 for five-byte frames). Any request arriving while `busy` is high, including one in the last busy cycle, has no effect.
- R9: With `cmd_valid` low, or with code 7, there is no memory access and `sp` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command: 0 push, 1 pop, 2 call, 3 return, 4 interrupt entry, 5 interrupt return, 6 reset pointer, 7 none |
| push_byte | input | 8 | Byte for a single push |
| pc_in | input | 16 | Program counter to save |
| x_in | input | 8 | X register to save |
| a_in | input | 8 | Accumulator to save |
| cc_in | input | 8 | Condition codes to save |
| mem_rdata | input | 8 | Asynchronous read data from stack memory |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Framed operation in progress |
| sp | output | 16 | Current stack pointer |
| pop_valid | output | 1 | One-cycle pulse: `pop_byte` holds a popped byte |
| pop_byte | output | 8 | Byte from the last single pop |
| restore_valid | output | 1 | One-cycle pulse: a return finished |
| pc_out | output | 16 | Restored program counter |
| x_out | output | 8 | Restored X |
| a_out | output | 8 | Restored accumulator |
| cc_out | output | 8 | Restored condition codes |

## Verification
Two things can fall in the same cycle: the final byte of a framed sequence and a new request from the core. The bench holds a push request, and separately a reset-pointer request, across every busy cycle of an interrupt entry, including the last one. It then judges the outcome from `sp` and from the contents of the stack memory model: the frame must be intact, the pointer must be lowered by exactly five, and a sentinel byte below the frame must be untouched. The pointer wrap at each end of the window also coincides with a memory access, and the bench checks that access's address in the same cycle.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int          STK_ADDR_W    = 16;
    localparam int          STK_DEPTH_LOG = 6;
    localparam logic [15:0] STK_BASE      = 16'h0100;

    typedef enum logic [2:0] {
        CMD_PUSH = 3'd0,
        CMD_POP  = 3'd1,
        CMD_CALL = 3'd2,
        CMD_RET  = 3'd3,
        CMD_IRQ  = 3'd4,
        CMD_IRET = 3'd5,
        CMD_RSP  = 3'd6,
        CMD_NONE = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        SLOT_PCL  = 3'd0,
        SLOT_PCH  = 3'd1,
        SLOT_X    = 3'd2,
        SLOT_A    = 3'd3,
        SLOT_CC   = 3'd4,
        SLOT_DATA = 3'd5
    } slot_e;

    typedef struct packed {
        logic [15:0] pc;
        logic [7:0]  x;
        logic [7:0]  a;
        logic [7:0]  cc;
    } ctx_t;

    // Number of bytes a command moves; zero for commands with no memory access.
    function automatic logic [2:0] frame_len(cmd_e c);
        case (c)
            CMD_PUSH, CMD_POP: return 3'd1;
            CMD_CALL, CMD_RET: return 3'd2;
            CMD_IRQ, CMD_IRET: return 3'd5;
            default:           return 3'd0;
        endcase
    endfunction

    function automatic logic is_store(cmd_e c);
        return (c == CMD_PUSH) || (c == CMD_CALL) || (c == CMD_IRQ);
    endfunction

    function automatic logic is_return(cmd_e c);
        return (c == CMD_RET) || (c == CMD_IRET);
    endfunction

    // Which context byte a given step of a command touches.
    function automatic slot_e slot_of(cmd_e c, logic [2:0] idx);
        slot_e s;
        s = SLOT_DATA;
        case (c)
            CMD_CALL: s = (idx == 3'd0) ? SLOT_PCL : SLOT_PCH;
            CMD_RET:  s = (idx == 3'd0) ? SLOT_PCH : SLOT_PCL;
            CMD_IRQ: begin
                case (idx)
                    3'd0:    s = SLOT_PCL;
                    3'd1:    s = SLOT_PCH;
                    3'd2:    s = SLOT_X;
                    3'd3:    s = SLOT_A;
                    default: s = SLOT_CC;
                endcase
            end
            CMD_IRET: begin
                case (idx)
                    3'd0:    s = SLOT_CC;
                    3'd1:    s = SLOT_A;
                    3'd2:    s = SLOT_X;
                    3'd3:    s = SLOT_PCH;
                    default: s = SLOT_PCL;
                endcase
            end
            default: s = SLOT_DATA;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/stk_seq.sv
module stk_seq
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    output logic       op_go,
    output cmd_e       op_cmd,
    output slot_e      op_slot,
    output logic       op_write,
    output logic       op_last,
    output logic       accept,
    output logic       rsp_go,
    output logic       busy
);

    logic       active_q;
    cmd_e       cmd_q;
    logic [2:0] idx_q;
    cmd_e       req_cmd;
    logic [2:0] op_idx;
    logic [2:0] op_len;

    assign req_cmd = cmd_e'(cmd_code);

    always_comb begin
        op_cmd   = active_q ? cmd_q : req_cmd;
        op_idx   = active_q ? idx_q : 3'd0;
        op_len   = frame_len(op_cmd);
        accept   = !active_q && cmd_valid && (frame_len(req_cmd) != 3'd0);
        op_go    = active_q || accept;
        op_last  = (op_idx == (op_len - 3'd1));
        op_slot  = slot_of(op_cmd, op_idx);
        op_write = is_store(op_cmd);
        rsp_go   = !active_q && cmd_valid && (req_cmd == CMD_RSP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cmd_q    <= CMD_NONE;
            idx_q    <= 3'd0;
        end else if (op_go && !op_last) begin
            active_q <= 1'b1;
            cmd_q    <= op_cmd;
            idx_q    <= op_idx + 3'd1;
        end else begin
            active_q <= 1'b0;
            idx_q    <= 3'd0;
        end
    end

    assign busy = active_q;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_last) |=> busy);                                   // R8
    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        (busy && op_last) |=> !busy);                                   // R8
    AST_SINGLE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_cmd == CMD_PUSH || req_cmd == CMD_POP)) |=> !busy); // R3

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int DEPTH_LOG = stk_pkg::STK_DEPTH_LOG
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rsp_go,
    input  logic                 op_go,
    input  logic                 op_write,
    output logic [DEPTH_LOG-1:0] off,
    output logic [DEPTH_LOG-1:0] off_up
);

    localparam logic [DEPTH_LOG-1:0] TOP = '1;
    localparam logic [DEPTH_LOG-1:0] ONE = DEPTH_LOG'(1);

    logic [DEPTH_LOG-1:0] off_q;
    logic [DEPTH_LOG-1:0] off_dn;

    // Natural modulo arithmetic gives the silent wrap at both window ends.
    assign off_up = off_q + ONE;
    assign off_dn = off_q - ONE;
    assign off    = off_q;

    always_ff @(posedge clk) begin
        if (rst || rsp_go) begin
            off_q <= TOP;
        end else if (op_go) begin
            off_q <= op_write ? off_dn : off_up;
        end
    end

    AST_RSP_TOP: assert property (@(posedge clk) disable iff (rst)
        rsp_go |=> (off == TOP));                                       // R2
    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_write) |=> (off == $past(off) - ONE));             // R4
    AST_POP_INC: assert property (@(posedge clk) disable iff (rst)
        (op_go && !op_write) |=> (off == $past(off) + ONE));            // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!op_go && !rsp_go) |=> $stable(off));                          // R9

endmodule

// File: rtl/stk_frame.sv
module stk_frame
    import stk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic        op_go,
    input  cmd_e        op_cmd,
    input  slot_e       op_slot,
    input  logic        op_write,
    input  logic        op_last,
    input  logic [7:0]  push_byte,
    input  ctx_t        ctx_live,
    input  logic [7:0]  rdata,
    output logic [7:0]  wdata,
    output logic        pop_valid,
    output logic [7:0]  pop_byte,
    output logic        restore_valid,
    output ctx_t        ctx_restored
);

    ctx_t       ctx_hold;
    ctx_t       ctx_src;
    ctx_t       rest_q;
    logic [7:0] pop_q;
    logic       pop_v_q;
    logic       rest_v_q;

    // The first byte goes out in the accept cycle from the live inputs; the
    // remaining bytes come from the copy captured at that same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_hold <= '0;
        end else if (accept) begin
            ctx_hold <= ctx_live;
        end
    end

    assign ctx_src = accept ? ctx_live : ctx_hold;

    always_comb begin
        case (op_slot)
            SLOT_PCL: wdata = ctx_src.pc[7:0];
            SLOT_PCH: wdata = ctx_src.pc[15:8];
            SLOT_X:   wdata = ctx_src.x;
            SLOT_A:   wdata = ctx_src.a;
            SLOT_CC:  wdata = ctx_src.cc;
            default:  wdata = push_byte;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rest_q   <= '0;
            pop_q    <= 8'h00;
            pop_v_q  <= 1'b0;
            rest_v_q <= 1'b0;
        end else begin
            pop_v_q  <= op_go && !op_write && (op_cmd == CMD_POP);
            rest_v_q <= op_go && !op_write && op_last && is_return(op_cmd);
            if (op_go && !op_write) begin
                case (op_slot)
                    SLOT_PCL: rest_q.pc[7:0]  <= rdata;
                    SLOT_PCH: rest_q.pc[15:8] <= rdata;
                    SLOT_X:   rest_q.x        <= rdata;
                    SLOT_A:   rest_q.a        <= rdata;
                    SLOT_CC:  rest_q.cc       <= rdata;
                    default:  pop_q           <= rdata;
                endcase
            end
        end
    end

    assign pop_valid     = pop_v_q;
    assign pop_byte      = pop_q;
    assign restore_valid = rest_v_q;
    assign ctx_restored  = rest_q;

    AST_CALL_ORDER: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_write && op_slot == SLOT_PCH)
            |-> $past(op_go && op_write && op_slot == SLOT_PCL));       // R6
    AST_IRQ_ORDER: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_write && op_slot == SLOT_CC)
            |-> $past(op_go && op_slot == SLOT_A));                     // R7
    AST_RET_LOW_LAST: assert property (@(posedge clk) disable iff (rst)
        (op_go && !op_write && op_slot == SLOT_PCL) |-> op_last);       // R7

endmodule

// File: rtl/stk_ctx_unit.sv
module stk_ctx_unit
    import stk_pkg::*;
#(
    parameter int          ADDR_W     = stk_pkg::STK_ADDR_W,
    parameter int          DEPTH_LOG  = stk_pkg::STK_DEPTH_LOG,
    parameter logic [15:0] STACK_BASE = stk_pkg::STK_BASE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic [7:0]        push_byte,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        x_in,
    input  logic [7:0]        a_in,
    input  logic [7:0]        cc_in,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] sp,
    output logic              pop_valid,
    output logic [7:0]        pop_byte,
    output logic              restore_valid,
    output logic [15:0]       pc_out,
    output logic [7:0]        x_out,
    output logic [7:0]        a_out,
    output logic [7:0]        cc_out
);

    localparam int HI_W = ADDR_W - DEPTH_LOG;
    localparam logic [HI_W-1:0] PAGE = HI_W'(STACK_BASE >> DEPTH_LOG);

    logic                 op_go, op_write, op_last, accept, rsp_go;
    cmd_e                 op_cmd;
    slot_e                op_slot;
    logic [DEPTH_LOG-1:0] off, off_up;
    ctx_t                 ctx_live, ctx_rest;

    assign ctx_live = '{pc: pc_in, x: x_in, a: a_in, cc: cc_in};

    stk_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .op_go    (op_go),
        .op_cmd   (op_cmd),
        .op_slot  (op_slot),
        .op_write (op_write),
        .op_last  (op_last),
        .accept   (accept),
        .rsp_go   (rsp_go),
        .busy     (busy)
    );

    stk_ptr #(.DEPTH_LOG(DEPTH_LOG)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .rsp_go  (rsp_go),
        .op_go   (op_go),
        .op_write(op_write),
        .off     (off),
        .off_up  (off_up)
    );

    stk_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .op_go        (op_go),
        .op_cmd       (op_cmd),
        .op_slot      (op_slot),
        .op_write     (op_write),
        .op_last      (op_last),
        .push_byte    (push_byte),
        .ctx_live     (ctx_live),
        .rdata        (mem_rdata),
        .wdata        (mem_wdata),
        .pop_valid    (pop_valid),
        .pop_byte     (pop_byte),
        .restore_valid(restore_valid),
        .ctx_restored (ctx_rest)
    );

    assign sp       = {PAGE, off};
    assign mem_we   = op_go && op_write;
    assign mem_re   = op_go && !op_write;
    assign mem_addr = {PAGE, (op_write ? off : off_up)};

    assign pc_out = ctx_rest.pc;
    assign x_out  = ctx_rest.x;
    assign a_out  = ctx_rest.a;
    assign cc_out = ctx_rest.cc;

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));                                           // R3
    AST_RESET_TOP: assert property (@(posedge clk)
        rst |=> (sp == {PAGE, {DEPTH_LOG{1'b1}}}));                     // R2
    AST_NO_OP_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid && !busy) |-> !(mem_we || mem_re));                 // R9

endmodule

// File: tb/stk_ctx_unit_bench.sv
module stk_ctx_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd7;
    logic [7:0]  push_byte = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  x_in = 8'h00, a_in = 8'h00, cc_in = 8'h00;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr, sp, pc_out;
    logic        mem_we, mem_re, busy, pop_valid, restore_valid;
    logic [7:0]  mem_wdata, pop_byte, x_out, a_out, cc_out;

    logic [7:0]  mem [64];
    int          n_checks = 0;
    int          n_fail = 0;
    int          window_err = 0;
    logic [15:0] seen_addr;
    logic        seen_we, seen_re;

    always #2 clk = ~clk;

    stk_ctx_unit u_stk_ctx_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .push_byte(push_byte), .pc_in(pc_in), .x_in(x_in), .a_in(a_in),
        .cc_in(cc_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata), .busy(busy),
        .sp(sp), .pop_valid(pop_valid), .pop_byte(pop_byte),
        .restore_valid(restore_valid), .pc_out(pc_out), .x_out(x_out),
        .a_out(a_out), .cc_out(cc_out)
    );

    assign mem_rdata = mem[mem_addr[5:0]];

    always @(posedge clk) if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;

    always @(negedge clk)
        if ((mem_we || mem_re) && mem_addr[15:6] != 10'h004) window_err++;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Present a command for one edge; records the accept-cycle access.
    task automatic issue(logic [2:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        #1;
        seen_addr = mem_addr;
        seen_we   = mem_we;
        seen_re   = mem_re;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cmd_code  = 3'd7;
    endtask

    task automatic push(logic [7:0] b);
        push_byte = b;
        issue(3'd0);
    endtask

    task automatic t_reset();
        check("R2 reset sp", 32'(sp), 32'h013F);
        check("R8 reset busy", 32'(busy), 0);
        check("R9 idle no access", 32'({mem_we, mem_re}), 0);
    endtask

    task automatic t_push_pop();
        push(8'hA5);
        check("R3 push addr", 32'(seen_addr), 32'h013F);
        check("R3 push we", 32'({seen_we, seen_re}), 32'b10);
        check("R3 push sp", 32'(sp), 32'h013E);
        check("R3 push mem", 32'(mem[63]), 32'hA5);
        issue(3'd1);
        check("R3 pop addr", 32'(seen_addr), 32'h013F);
        check("R3 pop re", 32'({seen_we, seen_re}), 32'b01);
        check("R3 pop valid", 32'(pop_valid), 1);
        check("R3 pop byte", 32'(pop_byte), 32'hA5);
        check("R3 pop sp", 32'(sp), 32'h013F);
        step();
        check("R3 pop valid pulse", 32'(pop_valid), 0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = 3'd7;
        #1;
        check("R9 code7 no access", 32'({mem_we, mem_re}), 0);
        step();
        cmd_valid = 1'b0;
        check("R9 code7 sp", 32'(sp), 32'h013F);
    endtask

    task automatic t_call_ret();
        int bc;
        pc_in = 16'h1234;
        mem[62] = 8'h00;
        issue(3'd2);
        pc_in = 16'hFFFF;
        bc = 0;
        while (busy) begin bc++; step(); end
        check("R8 call busy cycles", 32'(bc), 1);
        check("R6 call pcl", 32'(mem[63]), 32'h34);
        check("R6 call pch", 32'(mem[62]), 32'h12);
        check("R6 call sp", 32'(sp), 32'h013D);
        issue(3'd3);
        check("R6 ret first addr", 32'(seen_addr), 32'h013E);
        step();
        check("R6 ret valid", 32'(restore_valid), 1);
        check("R6 ret pc", 32'(pc_out), 32'h1234);
        check("R6 ret sp", 32'(sp), 32'h013F);
        pc_in = 16'h0000;
    endtask

    // Interrupt entry with requests held across every busy cycle, incl. the last.
    task automatic t_irq_collide();
        int bc;
        mem[58] = 8'h5A;
        pc_in = 16'hBEEF; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h0B;
        push_byte = 8'hC3;
        issue(3'd4);
        pc_in = 16'h0000; x_in = 8'h00; a_in = 8'h00; cc_in = 8'h00;
        bc = 0;
        cmd_valid = 1'b1; cmd_code = 3'd0;
        while (busy) begin
            bc++;
            if (bc == 2) cmd_code = 3'd6;
            if (bc == 3) cmd_code = 3'd0;
            @(posedge clk); #1;
        end
        cmd_valid = 1'b0; cmd_code = 3'd7;
        check("R8 irq busy cycles", 32'(bc), 4);
        check("R7 irq pcl", 32'(mem[63]), 32'hEF);
        check("R7 irq pch", 32'(mem[62]), 32'hBE);
        check("R7 irq x", 32'(mem[61]), 32'h11);
        check("R7 irq a", 32'(mem[60]), 32'h22);
        check("R7 irq cc", 32'(mem[59]), 32'h0B);
        check("R8 ignored push sentinel", 32'(mem[58]), 32'h5A);
        check("R8 ignored sp", 32'(sp), 32'h013A);
        issue(3'd5);
        check("R7 iret first addr", 32'(seen_addr), 32'h013B);
        while (busy) step();
        check("R7 iret valid", 32'(restore_valid), 1);
        check("R7 iret pc", 32'(pc_out), 32'hBEEF);
        check("R7 iret x", 32'(x_out), 32'h11);
        check("R7 iret a", 32'(a_out), 32'h22);
        check("R7 iret cc", 32'(cc_out), 32'h0B);
        check("R7 iret sp", 32'(sp), 32'h013F);
    endtask

    task automatic t_wrap();
        issue(3'd6);
        check("R2 rsp no access", 32'({seen_we, seen_re}), 0);
        for (int i = 0; i < 64; i++) push(8'(i));
        check("R4 wrap sp", 32'(sp), 32'h013F);
        check("R4 bottom byte", 32'(mem[0]), 32'd63);
        push(8'hEE);
        check("R4 overwrite", 32'(mem[63]), 32'hEE);
        check("R4 after overwrite sp", 32'(sp), 32'h013E);
        issue(3'd6);
        check("R2 rsp sp", 32'(sp), 32'h013F);
        issue(3'd1);
        check("R5 wrap pop addr", 32'(seen_addr), 32'h0100);
        check("R5 wrap pop byte", 32'(pop_byte), 32'd63);
        check("R5 wrap sp", 32'(sp), 32'h0100);
        issue(3'd1);
        check("R5 next pop byte", 32'(pop_byte), 32'd62);
    endtask

    initial begin
        fork
            begin
                for (int i = 0; i < 64; i++) mem[i] = 8'h00;
                repeat (3) @(posedge clk);
                #1 rst = 1'b0;
                t_reset();
                t_push_pop();
                t_idle();
                t_call_ret();
                t_irq_collide();
                t_wrap();
                check("R1 window", 32'(window_err), 0);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule